// File: doc/BRIEF.md
# Floating-Point Opcode Decoder with Register Banking

This block takes 16-bit floating-point opcodes and turns each one into an operation number plus physical register indices for a 32-entry floating-point register file. It owns the floating-point control register. Every register number it reports goes through the bank-select remap. For paired transfers, it also applies the rule that an odd register number names a pair in the opposite bank. The three flag-toggle opcodes are carried out inside the block, by flipping the selected control bit in place.

Each opcode is presented with a one-cycle `op_valid` strobe. The decoded result appears on the registered outputs one cycle later, together with an `out_valid` pulse. The decoder does no arithmetic, memory access or register-file storage. It only classifies the operation. Square root, reciprocal square root, inner product, matrix transform and sine/cosine are decoded and then marked as unimplemented. Software or a neighbouring block can load the control register through a dedicated write port.

Top module: `fpdec_top`

## Requirements
- R1: After reset the control register reads 0x00040001, with the bank (bit 21), size (bit 20) and precision (bit 19) bits clear, and `out_valid` is 0.
- R2: A write on the control port loads `ctl_wdata & 0x003FFFFF` on the next edge, so bits 31:22 always read 0. A write in the same cycle as a toggle opcode wins over the toggle.
- R3: All decode outputs are registered. They reflect the opcode of the cycle in which `op_valid` was high, and `out_valid` is high exactly one cycle after each `op_valid` cycle.
- R4: For an opcode whose bits 15:12 are 0xF, n = bits 11:8, m = bits 7:4 and f = bits 3:0. For f from 0 to 0xC the op code equals f: 0 add, 1 sub, 2 mul, 3 div, 4 compare-equal, 5 compare-greater, 6 indexed load, 7 indexed store, 8 indirect load, 9 post-increment load, 10 indirect store, 11 pre-decrement store, 12 register copy. For f = 0xE (multiply-accumulate, with register 0 as the implied multiplier) the op code is 14. Operands are as follows. Arithmetic, compare and multiply-accumulate use src = m and dst = n. Loads use dst = n, and src = m taken as a general register with no remap. Stores use src = m, and dst = n taken as a general register with no remap. Copy uses src = m and dst = n.
- R5: For f = 0xD and m in 0 to 0xB or 0xE, the op code is 16 + m: 16 to-FPUL, 17 from-FPUL, 18 int-to-float, 19 truncate, 20 negate, 21 abs, 22 sqrt, 23 reciprocal sqrt, 24 load zero, 25 load one, 26 single-to-double, 27 double-to-single, 30 inner product. Both src and dst are n. The values m = 0xC and m = 0xD are invalid.
- R6: For f = 0xD and m = 0xF, let x = n. If x[1:0] = 3, the op code is 32 and the control bit selected by x[3:2] is flipped: 0 flips size (bit 20), 1 flips precision (bit 19), 2 flips bank (bit 21). If x[1:0] = 1, the op code is 33 (matrix transform). Otherwise the op code is 34 (sine/cosine).
- R7: Every floating-point register index is reported as the logical index XOR 16 when bank (bit 21) is set, and unchanged otherwise. General-register indices are never remapped.
- R8: In the move forms (f 6 to 0xC), when size (bit 20) is set, an odd floating-point register number r becomes r + 15 before the bank remap. Other ops ignore this rule.
- R9: `pair` equals precision for f 0 to 5 and for int-to-float and truncate. It equals size for the move forms. It is 1 for the two conversions, and 0 for every other op.
- R10: `t_write` is 1 for the two compares and 0 for every other op.
- R11: `unimpl` is 1 for op codes 22, 23, 30, 33 and 34, and 0 for every other op.
- R12: For an opcode whose bits 15:12 are not 0xF, mask it with 0xF0FF. The masked values 0x006A, 0x005A, 0x406A and 0x405A give op codes 36, 37, 38 and 39, with src = dst = n as a general register. Any other such opcode, and f = 0xF, gives op 63 with `invalid` = 1, src = dst = 0 and the pair, t_write and unimpl flags all 0.
- R13: The toggle form with x[3:2] = 3 leaves the control register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Opcode strobe |
| opcode | input | 16 | Opcode to decode |
| ctl_we | input | 1 | Control register write enable |
| ctl_wdata | input | 32 | Control register write data |
| out_valid | output | 1 | Decode result valid |
| op_code | output | 6 | Operation number |
| src_idx | output | 5 | Physical source index |
| dst_idx | output | 5 | Physical destination index |
| pair | output | 1 | Double-width or pair access |
| t_write | output | 1 | Op drives the T status bit |
| unimpl | output | 1 | Decoded but not implemented |
| invalid | output | 1 | Invalid opcode |
| ctl_q | output | 32 | Control register contents |

## Verification
The assertions check several properties on every cycle. The upper control bits stay clear, and a port write always lands masked on the next edge. `out_valid` tracks the strobe. Invalid results carry no indices or flags, and only compares drive T. The bank toggle and the empty toggle each have their own property. Only the bench's reference model can show that the full op mapping, the interplay of bank XOR with the odd-pair extension, and the pair flag are right for each control setting. It shows this over directed opcodes and a seeded random stream with interleaved control writes.

// File: rtl/fpdec_pkg.sv
package fpdec_pkg;
    localparam int IDX_W  = 5;
    localparam int OP_W   = 6;
    localparam int CTL_W  = 32;
    localparam int NIB_W  = 4;
    localparam int PR_BIT = 19;
    localparam int SZ_BIT = 20;
    localparam int BK_BIT = 21;
    localparam logic [CTL_W-1:0] CTL_MASK = 32'h003F_FFFF;

    typedef enum logic [OP_W-1:0] {
        OP_FADD    = 6'd0,  OP_FSUB   = 6'd1,  OP_FMUL   = 6'd2,  OP_FDIV  = 6'd3,
        OP_CMPEQ   = 6'd4,  OP_CMPGT  = 6'd5,  OP_LD_IDX = 6'd6,  OP_ST_IDX = 6'd7,
        OP_LD_IND  = 6'd8,  OP_LD_INC = 6'd9,  OP_ST_IND = 6'd10, OP_ST_DEC = 6'd11,
        OP_COPY    = 6'd12, OP_MAC    = 6'd14,
        OP_TO_UL   = 6'd16, OP_FROM_UL = 6'd17, OP_ITOF  = 6'd18, OP_TRUNC = 6'd19,
        OP_NEG     = 6'd20, OP_ABS    = 6'd21, OP_SQRT   = 6'd22, OP_RSQRT = 6'd23,
        OP_ZERO    = 6'd24, OP_ONE    = 6'd25, OP_S2D    = 6'd26, OP_D2S   = 6'd27,
        OP_DOT     = 6'd30, OP_TOGGLE = 6'd32, OP_XFORM  = 6'd33, OP_SINCOS = 6'd34,
        OP_GR_CTL  = 6'd36, OP_GR_UL  = 6'd37, OP_CTL_GR = 6'd38, OP_UL_GR = 6'd39,
        OP_INVALID = 6'd63
    } op_e;

    typedef struct packed {
        op_e              op;
        logic [IDX_W-1:0] src;
        logic [IDX_W-1:0] dst;
        logic             map_src;
        logic             map_dst;
        logic             pair;
        logic             t_wr;
        logic             unimpl;
        logic             invalid;
        logic             tgl_en;
        logic [IDX_W-1:0] tgl_pos;
    } dec_t;
endpackage

// File: rtl/fpdec_bankmap.sv
module fpdec_bankmap
    import fpdec_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    input  logic             apply,
    input  logic             bank,
    output logic [IDX_W-1:0] phys
);
    localparam int HALF = 1 << (IDX_W - 1);

    // Bank select swaps the two halves of the register file (R7)
    always_comb begin
        phys = idx;
        if (apply && bank) begin
            phys = idx ^ IDX_W'(HALF);
        end
    end
endmodule

// File: rtl/fpdec_fgroup.sv
module fpdec_fgroup
    import fpdec_pkg::*;
(
    input  logic [11:0] body,
    input  logic        size,
    input  logic        prec,
    output dec_t        dec
);
    logic [NIB_W-1:0] n_f, m_f, fn_f;

    // Odd register in a paired move names the opposite bank's pair (R8)
    function automatic logic [IDX_W-1:0] pair_ext(input logic [NIB_W-1:0] r, input logic sz);
        logic [IDX_W-1:0] w;
        w = {1'b0, r};
        if (sz && r[0]) begin
            w = w + IDX_W'(15);
        end
        return w;
    endfunction

    always_comb begin
        n_f  = body[11:8];
        m_f  = body[7:4];
        fn_f = body[3:0];
        dec  = '0;
        dec.op = OP_INVALID;
        dec.invalid = 1'b1;
        case (fn_f)
            4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5: begin
                dec.invalid = 1'b0;
                dec.op      = op_e'({2'b00, fn_f});
                dec.src     = {1'b0, m_f};
                dec.dst     = {1'b0, n_f};
                dec.map_src = 1'b1;
                dec.map_dst = 1'b1;
                dec.pair    = prec;
                dec.t_wr    = (fn_f == 4'h4) || (fn_f == 4'h5);
            end
            4'hE: begin
                dec.invalid = 1'b0;
                dec.op      = OP_MAC;
                dec.src     = {1'b0, m_f};
                dec.dst     = {1'b0, n_f};
                dec.map_src = 1'b1;
                dec.map_dst = 1'b1;
            end
            4'h6, 4'h8, 4'h9: begin
                dec.invalid = 1'b0;
                dec.op      = op_e'({2'b00, fn_f});
                dec.src     = {1'b0, m_f};
                dec.dst     = pair_ext(n_f, size);
                dec.map_dst = 1'b1;
                dec.pair    = size;
            end
            4'h7, 4'hA, 4'hB: begin
                dec.invalid = 1'b0;
                dec.op      = op_e'({2'b00, fn_f});
                dec.src     = pair_ext(m_f, size);
                dec.dst     = {1'b0, n_f};
                dec.map_src = 1'b1;
                dec.pair    = size;
            end
            4'hC: begin
                dec.invalid = 1'b0;
                dec.op      = OP_COPY;
                dec.src     = pair_ext(m_f, size);
                dec.dst     = pair_ext(n_f, size);
                dec.map_src = 1'b1;
                dec.map_dst = 1'b1;
                dec.pair    = size;
            end
            4'hD: begin
                if (m_f != 4'hC && m_f != 4'hD) begin
                    dec.invalid = 1'b0;
                    dec.src     = {1'b0, n_f};
                    dec.dst     = {1'b0, n_f};
                    dec.map_src = 1'b1;
                    dec.map_dst = 1'b1;
                    if (m_f == 4'hF) begin
                        if (n_f[1:0] == 2'b11) begin
                            dec.op     = OP_TOGGLE;
                            dec.tgl_en = (n_f[3:2] != 2'b11);
                            case (n_f[3:2])
                                2'b00:   dec.tgl_pos = IDX_W'(SZ_BIT);
                                2'b01:   dec.tgl_pos = IDX_W'(PR_BIT);
                                default: dec.tgl_pos = IDX_W'(BK_BIT);
                            endcase
                        end else if (n_f[1:0] == 2'b01) begin
                            dec.op     = OP_XFORM;
                            dec.unimpl = 1'b1;
                        end else begin
                            dec.op     = OP_SINCOS;
                            dec.unimpl = 1'b1;
                        end
                    end else begin
                        dec.op     = op_e'(6'd16 + {2'b00, m_f});
                        dec.pair   = ((m_f == 4'h2) || (m_f == 4'h3)) ? prec
                                   : ((m_f == 4'hA) || (m_f == 4'hB));
                        dec.unimpl = (m_f == 4'h6) || (m_f == 4'h7) || (m_f == 4'hE);
                    end
                end
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/fpdec_sysgroup.sv
module fpdec_sysgroup
    import fpdec_pkg::*;
(
    input  logic [15:0] opcode,
    output dec_t        dec
);
    logic [15:0] masked;

    always_comb begin
        masked = opcode & 16'hF0FF;
        dec    = '0;
        dec.op = OP_INVALID;
        dec.invalid = 1'b1;
        if (masked == 16'h006A || masked == 16'h005A ||
            masked == 16'h406A || masked == 16'h405A) begin
            dec.invalid = 1'b0;
            dec.src     = {1'b0, opcode[11:8]};
            dec.dst     = {1'b0, opcode[11:8]};
            // bit 14 picks direction, bit 4 picks FPUL over control
            dec.op      = op_e'(6'd36 + {4'b0000, opcode[14], opcode[4]});
        end
    end
endmodule

// File: rtl/fpdec_top.sv
module fpdec_top
    import fpdec_pkg::*;
#(
    parameter logic [31:0] CTL_RESET = 32'h0004_0001
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        op_valid,
    input  logic [15:0] opcode,
    input  logic        ctl_we,
    input  logic [31:0] ctl_wdata,
    output logic        out_valid,
    output logic [5:0]  op_code,
    output logic [4:0]  src_idx,
    output logic [4:0]  dst_idx,
    output logic        pair,
    output logic        t_write,
    output logic        unimpl,
    output logic        invalid,
    output logic [31:0] ctl_q
);
    localparam int NOPS = 2;

    typedef struct packed {
        logic [CTL_W-1:0] ctl;
        logic             vld;
        op_e              op;
        logic [IDX_W-1:0] src;
        logic [IDX_W-1:0] dst;
        logic             pair;
        logic             t_wr;
        logic             unimpl;
        logic             invalid;
    } state_t;

    state_t st_d, st_q;
    dec_t   f_dec, s_dec, sel_dec;

    logic [IDX_W-1:0] log_idx  [NOPS];
    logic             map_en   [NOPS];
    logic [IDX_W-1:0] phys_idx [NOPS];

    fpdec_fgroup u_fgroup (
        .body (opcode[11:0]),
        .size (st_q.ctl[SZ_BIT]),
        .prec (st_q.ctl[PR_BIT]),
        .dec  (f_dec)
    );

    fpdec_sysgroup u_sysgroup (
        .opcode (opcode),
        .dec    (s_dec)
    );

    always_comb begin
        sel_dec    = (opcode[15:12] == 4'hF) ? f_dec : s_dec;
        log_idx[0] = sel_dec.src;
        log_idx[1] = sel_dec.dst;
        map_en[0]  = sel_dec.map_src;
        map_en[1]  = sel_dec.map_dst;
    end

    for (genvar g = 0; g < NOPS; g++) begin : g_map
        fpdec_bankmap u_map (
            .idx   (log_idx[g]),
            .apply (map_en[g]),
            .bank  (st_q.ctl[BK_BIT]),
            .phys  (phys_idx[g])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = op_valid;
        if (op_valid) begin
            st_d.op      = sel_dec.op;
            st_d.src     = phys_idx[0];
            st_d.dst     = phys_idx[1];
            st_d.pair    = sel_dec.pair;
            st_d.t_wr    = sel_dec.t_wr;
            st_d.unimpl  = sel_dec.unimpl;
            st_d.invalid = sel_dec.invalid;
        end
        if (ctl_we) begin
            st_d.ctl = ctl_wdata & CTL_MASK;
        end else if (op_valid && sel_dec.tgl_en) begin
            st_d.ctl = st_q.ctl ^ (CTL_W'(1) << sel_dec.tgl_pos);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.ctl <= CTL_RESET & CTL_MASK;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign op_code   = st_q.op;
    assign src_idx   = st_q.src;
    assign dst_idx   = st_q.dst;
    assign pair      = st_q.pair;
    assign t_write   = st_q.t_wr;
    assign unimpl    = st_q.unimpl;
    assign invalid   = st_q.invalid;
    assign ctl_q     = st_q.ctl;
endmodule

// File: rtl/fpdec_chk.sv
module fpdec_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        op_valid,
    input logic [15:0] opcode,
    input logic        ctl_we,
    input logic [31:0] ctl_wdata,
    input logic        out_valid,
    input logic [5:0]  op_code,
    input logic [4:0]  src_idx,
    input logic [4:0]  dst_idx,
    input logic        pair,
    input logic        t_write,
    input logic        unimpl,
    input logic        invalid,
    input logic [31:0] ctl_q
);
    // R2
    ctl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we |=> ctl_q == ($past(ctl_wdata) & 32'h003F_FFFF));

    // R2
    ctl_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[31:22] == 10'd0);

    // R3
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> out_valid);

    // R3
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !out_valid);

    // R12
    invalid_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && invalid) |-> (src_idx == 5'd0 && dst_idx == 5'd0 &&
                                    !pair && !t_write && !unimpl && op_code == 6'd63));

    // R6
    bank_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode == 16'hFBFD && !ctl_we) |=> ctl_q[21] != $past(ctl_q[21]));

    // R13
    empty_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode == 16'hFFFD && !ctl_we) |=> $stable(ctl_q));

    // R10
    compare_t_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && t_write) |-> (op_code == 6'd4 || op_code == 6'd5));
endmodule

bind fpdec_top fpdec_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .opcode    (opcode),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .out_valid (out_valid),
    .op_code   (op_code),
    .src_idx   (src_idx),
    .dst_idx   (dst_idx),
    .pair      (pair),
    .t_write   (t_write),
    .unimpl    (unimpl),
    .invalid   (invalid),
    .ctl_q     (ctl_q)
);

// File: tb/fpdec_top_bench.sv
`timescale 1ns/1ps
module fpdec_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [15:0] opcode = 16'h0;
    logic        ctl_we = 1'b0;
    logic [31:0] ctl_wdata = 32'h0;
    logic        out_valid, pair, t_write, unimpl, invalid;
    logic [5:0]  op_code;
    logic [4:0]  src_idx, dst_idx;
    logic [31:0] ctl_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] m_ctl;

    typedef struct packed {
        logic [5:0]  op;
        logic [4:0]  src;
        logic [4:0]  dst;
        logic        pair;
        logic        tw;
        logic        un;
        logic        inv;
        logic [31:0] ctl;
    } exp_t;

    always #4 clk = ~clk;

    fpdec_top u_fpdec_top (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .out_valid(out_valid),
        .op_code(op_code), .src_idx(src_idx), .dst_idx(dst_idx), .pair(pair),
        .t_write(t_write), .unimpl(unimpl), .invalid(invalid), .ctl_q(ctl_q)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp, logic [15:0] c);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s opcode=%h actual=%h expected=%h", req, c, act, exp);
        end
    endtask

    function automatic logic [4:0] bmap(input logic [4:0] r, input logic bk);
        return bk ? (r ^ 5'd16) : r;
    endfunction

    function automatic logic [4:0] ext(input logic [3:0] r, input logic sz);
        return (sz && r[0]) ? ({1'b0, r} + 5'd15) : {1'b0, r};
    endfunction

    // Reference model built from R4..R13
    function automatic exp_t model(input logic [15:0] c, input logic [31:0] ctl);
        exp_t e;
        logic bk, sz, pr;
        logic [3:0] n, m, f;
        logic [15:0] mk;
        bk = ctl[21]; sz = ctl[20]; pr = ctl[19];
        n = c[11:8]; m = c[7:4]; f = c[3:0];
        e = '0; e.op = 6'd63; e.inv = 1'b1; e.ctl = ctl;
        if (c[15:12] == 4'hF) begin
            if (f <= 4'h5) begin
                e = '0; e.ctl = ctl; e.op = {2'b0, f};
                e.src = bmap({1'b0, m}, bk); e.dst = bmap({1'b0, n}, bk);
                e.pair = pr; e.tw = (f >= 4'h4);
            end else if (f == 4'hE) begin
                e = '0; e.ctl = ctl; e.op = 6'd14;
                e.src = bmap({1'b0, m}, bk); e.dst = bmap({1'b0, n}, bk);
            end else if (f == 4'h6 || f == 4'h8 || f == 4'h9) begin
                e = '0; e.ctl = ctl; e.op = {2'b0, f}; e.pair = sz;
                e.src = {1'b0, m}; e.dst = bmap(ext(n, sz), bk);
            end else if (f == 4'h7 || f == 4'hA || f == 4'hB) begin
                e = '0; e.ctl = ctl; e.op = {2'b0, f}; e.pair = sz;
                e.src = bmap(ext(m, sz), bk); e.dst = {1'b0, n};
            end else if (f == 4'hC) begin
                e = '0; e.ctl = ctl; e.op = 6'd12; e.pair = sz;
                e.src = bmap(ext(m, sz), bk); e.dst = bmap(ext(n, sz), bk);
            end else if (f == 4'hD && m != 4'hC && m != 4'hD) begin
                e = '0; e.ctl = ctl;
                e.src = bmap({1'b0, n}, bk); e.dst = e.src;
                if (m == 4'hF) begin
                    if (n[1:0] == 2'b11) begin
                        e.op = 6'd32;
                        if (n[3:2] == 2'd0) e.ctl[20] = ~ctl[20];
                        if (n[3:2] == 2'd1) e.ctl[19] = ~ctl[19];
                        if (n[3:2] == 2'd2) e.ctl[21] = ~ctl[21];
                    end else if (n[1:0] == 2'b01) begin
                        e.op = 6'd33; e.un = 1'b1;
                    end else begin
                        e.op = 6'd34; e.un = 1'b1;
                    end
                end else begin
                    e.op = 6'd16 + {2'b0, m};
                    e.pair = (m == 4'h2 || m == 4'h3) ? pr : (m == 4'hA || m == 4'hB);
                    e.un = (m == 4'h6 || m == 4'h7 || m == 4'hE);
                end
            end
        end else begin
            mk = c & 16'hF0FF;
            if (mk == 16'h006A || mk == 16'h005A || mk == 16'h406A || mk == 16'h405A) begin
                e = '0; e.ctl = ctl;
                e.src = {1'b0, n}; e.dst = {1'b0, n};
                e.op = (mk == 16'h006A) ? 6'd36 : (mk == 16'h005A) ? 6'd37
                     : (mk == 16'h406A) ? 6'd38 : 6'd39;
            end
        end
        return e;
    endfunction

    function automatic string op_req(input logic [15:0] c);
        if (c[15:12] != 4'hF || c[3:0] == 4'hF) return "R12";
        if (c[3:0] == 4'hD) return (c[7:4] == 4'hF) ? "R6" : "R5";
        return "R4";
    endfunction

    task automatic step(bit v, logic [15:0] c, bit we, logic [31:0] wd);
        exp_t e;
        logic [31:0] nxt;
        string ireq;
        op_valid = v; opcode = c; ctl_we = we; ctl_wdata = wd;
        e = model(c, m_ctl);
        ireq = (c[15:12] == 4'hF && c[3:0] >= 4'h6 && c[3:0] <= 4'hC && m_ctl[20]) ? "R8" : "R7";
        @(posedge clk);
        @(negedge clk);
        check("R3", {31'd0, out_valid}, {31'd0, v}, c);
        if (v) begin
            check(op_req(c), {26'd0, op_code}, {26'd0, e.op}, c);
            check(ireq, {27'd0, src_idx}, {27'd0, e.src}, c);
            check(ireq, {27'd0, dst_idx}, {27'd0, e.dst}, c);
            check("R9", {31'd0, pair}, {31'd0, e.pair}, c);
            check("R10", {31'd0, t_write}, {31'd0, e.tw}, c);
            check("R11", {31'd0, unimpl}, {31'd0, e.un}, c);
            check("R12", {31'd0, invalid}, {31'd0, e.inv}, c);
        end
        nxt = we ? (wd & 32'h003F_FFFF) : (v ? e.ctl : m_ctl);
        check(we ? "R2" : ((c == 16'hFFFD) ? "R13" : "R6"), ctl_q, nxt, c);
        m_ctl = nxt;
        op_valid = 1'b0; ctl_we = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0] c;
        logic [31:0] r;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", ctl_q, 32'h0004_0001, 16'h0);
        check("R1", {31'd0, out_valid}, 32'd0, 16'h0);
        rst_n = 1'b1;
        m_ctl = 32'h0004_0001;
        @(negedge clk);

        // R4 / R7 directed, bank clear then set
        step(1, 16'hF120, 0, 0);
        step(1, 16'hF354, 0, 0);
        step(1, 16'hF00E, 0, 0);
        step(0, 16'h0, 1, 32'hFFE0_0000);      // R2 mask: upper bits dropped
        step(1, 16'hF120, 1, 32'h0020_0000);   // R2 write beats nothing, bank set
        step(1, 16'hF3A1, 0, 0);
        // R8 size set: odd index moves to opposite pair
        step(0, 16'h0, 1, 32'h0010_0000);
        step(1, 16'hF31C, 0, 0);
        step(1, 16'hF52A, 0, 0);
        step(1, 16'hF786, 0, 0);
        step(1, 16'hF31C, 1, 32'h0030_0000);
        step(1, 16'hF31C, 0, 0);
        // R5 / R9 / R11 one-operand group
        step(1, 16'hF22D, 0, 0);
        step(1, 16'hF66D, 0, 0);
        step(1, 16'hF1AD, 0, 0);
        step(1, 16'hF1CD, 0, 0);               // invalid m=0xC
        // R6 toggles, R13 empty toggle, R2 write beats toggle
        step(1, 16'hFBFD, 0, 0);
        step(1, 16'hF3FD, 0, 0);
        step(1, 16'hF7FD, 0, 0);
        step(1, 16'hFFFD, 0, 0);
        step(1, 16'hFBFD, 1, 32'h0000_0003);
        step(1, 16'hF1FD, 0, 0);
        step(1, 16'hF2FD, 0, 0);
        // R12 general group and invalids
        step(1, 16'h056A, 0, 0);
        step(1, 16'h0A5A, 0, 0);
        step(1, 16'h476A, 0, 0);
        step(1, 16'h425A, 0, 0);
        step(1, 16'h4252, 0, 0);
        step(1, 16'hF12F, 0, 0);

        for (int i = 0; i < 3000; i++) begin
            r = $urandom;
            c = $urandom;
            if (r[1:0] != 2'b00) c[15:12] = 4'hF;
            else if (r[2]) begin
                case (r[4:3])
                    2'd0: c = 16'h006A; 2'd1: c = 16'h005A;
                    2'd2: c = 16'h406A; default: c = 16'h405A;
                endcase
                c[11:8] = r[8:5];
            end
            step(r[9] | r[10], c, r[13:11] == 3'b000, $urandom);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule